// File: doc/BRIEF.md
# Asynchronous Serial Character Receiver

This block receives characters from one asynchronous serial line. An external generator supplies a one-clock baud tick at sixteen times the bit rate. A falling edge on the idle-high line arms a start check half a bit later. If the line is still low at that check, the frame is accepted. The block then samples 7 or 8 data bits, least significant bit first, at their bit centres. A parity bit follows when parity is enabled, and one stop bit ends the frame.

When the stop bit has been sampled, the character goes into a receive buffer even if the frame is in error. The block also issues interrupt pulses. A routing bit chooses whether an errored frame still raises the normal completion pulse or raises only the error pulse. Software-side logic reads the buffer with a one-cycle strobe, and that read clears the full flag and the error flags. Clearing the enable bit aborts a frame in progress. No state the consumer can see changes when that happens.

Top module: `serrx_top`

## Requirements
- R1: After synchronous reset, `buf_full`, all three error flags, both interrupt pulses and `rx_data` are 0.
- R2: While `rx_en` is 0 the line is ignored: a complete frame driven on `rxd` loads nothing and raises no pulse.
- R3: A low level on `rxd` that has ended before the half-bit start check is discarded with no pulse and no buffer change. A proper frame after it is received correctly.
- R4: Data bits arrive least significant bit first. `char_len8`=1 selects 8 data bits and 0 selects 7, in which case `rx_data[7]` is 0.
- R5: `par_sel` encoding: 0 means no parity bit is present, 1 even, 2 odd, 3 the parity bit must be 0. A received parity bit that differs from the selected rule sets `err_parity`.
- R6: A stop bit sampled as 0 sets `err_frame`.
- R7: Each completed frame, errored or not, loads `rx_data` and sets `buf_full`.
- R8: An errored frame always gives exactly one `irq_err` pulse. `irq_done` also pulses for that frame when `err_route`=0, and does not pulse when `err_route`=1. A clean frame gives exactly one `irq_done` and no `irq_err`.
- R9: Clearing `rx_en` mid-frame stops reception. `rx_data`, `buf_full` and the error flags keep their values, and no pulse is issued.
- R10: A frame that completes while `buf_full` is 1 sets `err_overrun` and replaces `rx_data`. Error flags stay set until a read.
- R11: A one-cycle `rd_strobe` clears `buf_full`, `err_parity`, `err_frame` and `err_overrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-clock pulse at 16x bit rate |
| rx_en | input | 1 | Receive enable |
| err_route | input | 1 | 1: errored frames suppress `irq_done` |
| par_sel | input | 2 | Parity rule (0 none, 1 even, 2 odd, 3 zero) |
| char_len8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| rxd | input | 1 | Serial input, idle high |
| rd_strobe | input | 1 | One-cycle buffer read |
| rx_data | output | 8 | Receive buffer |
| buf_full | output | 1 | Buffer holds an unread character |
| err_parity | output | 1 | Parity error flag |
| err_frame | output | 1 | Framing error flag |
| err_overrun | output | 1 | Overrun error flag |
| irq_done | output | 1 | Completion interrupt pulse |
| irq_err | output | 1 | Error interrupt pulse |

## Verification
A falling edge on `rxd` reaches the state machine three clocks later, through two synchronizer flops and the edge register. The start check falls eight ticks after that, and each later bit is sampled sixteen ticks after the previous one. The buffer, the flags and the interrupt pulse all change one clock after the clock that carries the stop-bit centre tick. That clock comes about eight ticks before the bench stops driving the stop bit, so every result check is made after the full stop bit has been driven, plus two idle ticks. The interrupt pulses are tallied at every falling clock edge, so each check compares exact pulse counts per frame rather than looking for a pulse in one guessed cycle.

// File: rtl/serrx_pkg.sv
package serrx_pkg;

    localparam int DATA_W  = 8;
    localparam int IDX_W   = $clog2(DATA_W);

    typedef enum logic [1:0] {
        PAR_NONE = 2'd0,
        PAR_EVEN = 2'd1,
        PAR_ODD  = 2'd2,
        PAR_ZERO = 2'd3
    } par_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              perr;
        logic              ferr;
    } frame_res_t;

    // Parity bit the sender should have produced for the given character.
    function automatic logic want_parity(par_mode_e m, logic [DATA_W-1:0] d, logic len_full);
        logic [DATA_W-1:0] masked;
        masked = len_full ? d : {1'b0, d[DATA_W-2:0]};
        case (m)
            PAR_EVEN: want_parity = ^masked;
            PAR_ODD:  want_parity = ~(^masked);
            default:  want_parity = 1'b0;
        endcase
    endfunction

    function automatic logic [IDX_W-1:0] last_index(logic len_full);
        last_index = len_full ? IDX_W'(DATA_W - 1) : IDX_W'(DATA_W - 2);
    endfunction

endpackage

// File: rtl/serrx_sync.sv
module serrx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rxd,
    output logic rx_s,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '1;
            prev  <= 1'b1;
        end else begin
            chain <= {chain[STAGES-2:0], rxd};
            prev  <= chain[STAGES-1];
        end
    end

    assign rx_s = chain[STAGES-1];
    assign fall = prev & ~chain[STAGES-1];
endmodule

// File: rtl/serrx_bitclk.sv
module serrx_bitclk #(
    parameter int OVS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic clear,
    output logic half_hit,
    output logic full_hit
);
    localparam int CW   = $clog2(OVS) + 1;
    localparam int HALF = OVS / 2;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (tick) begin
            if (cnt == CW'(OVS - 1)) cnt <= '0;
            else                     cnt <= cnt + 1'b1;
        end
    end

    assign half_hit = tick && (cnt == CW'(HALF - 1));
    assign full_hit = tick && (cnt == CW'(OVS - 1));

    a_r3_count_range: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(OVS - 1));
endmodule

// File: rtl/serrx_frame.sv
module serrx_frame
    import serrx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_en,
    input  logic       len_full,
    input  par_mode_e  pmode,
    input  logic       rx_s,
    input  logic       fall,
    input  logic       half_hit,
    input  logic       full_hit,
    output logic       cnt_clear,
    output frame_res_t res,
    output logic       res_valid
);
    rx_state_e          state;
    logic [DATA_W-1:0]  shreg;
    logic [IDX_W-1:0]   bitidx;
    logic               par_bit;
    logic               accept;

    assign accept    = (state == ST_START) && half_hit && !rx_s;
    assign cnt_clear = (state == ST_IDLE) || accept || !rx_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            shreg     <= '0;
            bitidx    <= '0;
            par_bit   <= 1'b0;
            res       <= '0;
            res_valid <= 1'b0;
        end else begin
            res_valid <= 1'b0;
            if (!rx_en) begin
                state <= ST_IDLE;
            end else begin
                case (state)
                    ST_IDLE: begin
                        if (fall) state <= ST_START;
                    end
                    ST_START: begin
                        if (half_hit) begin
                            if (!rx_s) begin
                                state  <= ST_DATA;
                                shreg  <= '0;
                                bitidx <= '0;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    ST_DATA: begin
                        if (full_hit) begin
                            shreg[bitidx] <= rx_s;
                            if (bitidx == last_index(len_full)) begin
                                state <= (pmode == PAR_NONE) ? ST_STOP : ST_PAR;
                            end else begin
                                bitidx <= bitidx + 1'b1;
                            end
                        end
                    end
                    ST_PAR: begin
                        if (full_hit) begin
                            par_bit <= rx_s;
                            state   <= ST_STOP;
                        end
                    end
                    ST_STOP: begin
                        if (full_hit) begin
                            res.data  <= shreg;
                            res.perr  <= (pmode != PAR_NONE) &&
                                         (par_bit != want_parity(pmode, shreg, len_full));
                            res.ferr  <= !rx_s;
                            res_valid <= 1'b1;
                            state     <= ST_IDLE;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // R2 / R9: a disabled receiver never completes a frame
    a_r9_off_no_frame: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> !res_valid);
    // R9: disabling returns the sequencer to idle
    a_r9_off_idle: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> state == ST_IDLE);
    // R3: a high line at the start check abandons the frame
    a_r3_false_start: assert property (@(posedge clk) disable iff (rst)
        (rx_en && state == ST_START && half_hit && rx_s) |=> state == ST_IDLE);
    // R4: short characters never set the top data bit
    a_r4_short_top_zero: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !len_full) |-> !res.data[DATA_W-1]);
endmodule

// File: rtl/serrx_buffer.sv
module serrx_buffer
    import serrx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              res_valid,
    input  frame_res_t        res,
    input  logic              rd_strobe,
    input  logic              err_route,
    output logic [DATA_W-1:0] rx_data,
    output logic              buf_full,
    output logic              err_parity,
    output logic              err_frame,
    output logic              err_overrun,
    output logic              irq_done,
    output logic              irq_err
);
    logic ovr_now;
    logic any_err;
    logic keep_old;

    assign ovr_now  = buf_full && !rd_strobe;
    assign keep_old = !rd_strobe;
    assign any_err  = res.perr || res.ferr || ovr_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_data     <= '0;
            buf_full    <= 1'b0;
            err_parity  <= 1'b0;
            err_frame   <= 1'b0;
            err_overrun <= 1'b0;
            irq_done    <= 1'b0;
            irq_err     <= 1'b0;
        end else begin
            irq_done <= 1'b0;
            irq_err  <= 1'b0;
            if (res_valid) begin
                rx_data     <= res.data;
                buf_full    <= 1'b1;
                err_parity  <= res.perr || (keep_old && err_parity);
                err_frame   <= res.ferr || (keep_old && err_frame);
                err_overrun <= ovr_now  || (keep_old && err_overrun);
                irq_err     <= any_err;
                irq_done    <= !(any_err && err_route);
            end else if (rd_strobe) begin
                buf_full    <= 1'b0;
                err_parity  <= 1'b0;
                err_frame   <= 1'b0;
                err_overrun <= 1'b0;
            end
        end
    end

    // R7: a completed frame leaves the buffer full
    a_r7_full_after_frame: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> buf_full);
    // R8: with routing set, an errored frame gives no completion pulse
    a_r8_route_suppress: assert property (@(posedge clk) disable iff (rst)
        (res_valid && err_route && (res.perr || res.ferr)) |=> (irq_err && !irq_done));
    // R8: the two pulses never both stay silent for a completed frame
    a_r8_some_pulse: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> (irq_done || irq_err));
    // R10: overrun only rises when the buffer was already full
    a_r10_overrun_src: assert property (@(posedge clk) disable iff (rst)
        $rose(err_overrun) |-> $past(buf_full));
    // R11: a read with no new frame clears full and all flags
    a_r11_read_clears: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && !res_valid) |=> !(buf_full || err_parity || err_frame || err_overrun));
endmodule

// File: rtl/serrx_top.sv
module serrx_top
    import serrx_pkg::*;
#(
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       baud_tick,
    input  logic       rx_en,
    input  logic       err_route,
    input  logic [1:0] par_sel,
    input  logic       char_len8,
    input  logic       rxd,
    input  logic       rd_strobe,
    output logic [7:0] rx_data,
    output logic       buf_full,
    output logic       err_parity,
    output logic       err_frame,
    output logic       err_overrun,
    output logic       irq_done,
    output logic       irq_err
);
    logic       rx_s;
    logic       fall;
    logic       half_hit;
    logic       full_hit;
    logic       cnt_clear;
    logic       res_valid;
    frame_res_t res;

    serrx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .rxd  (rxd),
        .rx_s (rx_s),
        .fall (fall)
    );

    serrx_bitclk #(.OVS(OVS)) u_bitclk (
        .clk      (clk),
        .rst      (rst),
        .tick     (baud_tick),
        .clear    (cnt_clear),
        .half_hit (half_hit),
        .full_hit (full_hit)
    );

    serrx_frame u_frame (
        .clk       (clk),
        .rst       (rst),
        .rx_en     (rx_en),
        .len_full  (char_len8),
        .pmode     (par_mode_e'(par_sel)),
        .rx_s      (rx_s),
        .fall      (fall),
        .half_hit  (half_hit),
        .full_hit  (full_hit),
        .cnt_clear (cnt_clear),
        .res       (res),
        .res_valid (res_valid)
    );

    serrx_buffer u_buffer (
        .clk         (clk),
        .rst         (rst),
        .res_valid   (res_valid),
        .res         (res),
        .rd_strobe   (rd_strobe),
        .err_route   (err_route),
        .rx_data     (rx_data),
        .buf_full    (buf_full),
        .err_parity  (err_parity),
        .err_frame   (err_frame),
        .err_overrun (err_overrun),
        .irq_done    (irq_done),
        .irq_err     (irq_err)
    );
endmodule

// File: tb/serrx_top_bench.sv
`timescale 1ns/1ps
module serrx_top_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       baud_tick = 1'b0;
    logic       rx_en = 1'b0;
    logic       err_route = 1'b0;
    logic [1:0] par_sel = 2'd0;
    logic       char_len8 = 1'b1;
    logic       rxd = 1'b1;
    logic       rd_strobe = 1'b0;
    logic [7:0] rx_data;
    logic       buf_full, err_parity, err_frame, err_overrun, irq_done, irq_err;

    int checks = 0;
    int failures = 0;
    int n_done = 0;
    int n_err = 0;
    logic [1:0] tdiv = 2'd0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    serrx_top u_serrx_top (
        .clk(clk), .rst(rst), .baud_tick(baud_tick), .rx_en(rx_en),
        .err_route(err_route), .par_sel(par_sel), .char_len8(char_len8),
        .rxd(rxd), .rd_strobe(rd_strobe), .rx_data(rx_data),
        .buf_full(buf_full), .err_parity(err_parity), .err_frame(err_frame),
        .err_overrun(err_overrun), .irq_done(irq_done), .irq_err(irq_err)
    );

    always @(posedge clk) begin
        tdiv      <= tdiv + 2'd1;
        baud_tick <= (tdiv == 2'd3);
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (irq_done) n_done <= n_done + 1;
            if (irq_err)  n_err  <= n_err + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            do @(negedge clk); while (!baud_tick);
        end
    endtask

    function automatic logic par_of(input logic [7:0] d, input logic len8, input logic [1:0] m);
        logic [7:0] md;
        md = len8 ? d : {1'b0, d[6:0]};
        case (m)
            2'd1:    par_of = ^md;
            2'd2:    par_of = ~(^md);
            default: par_of = 1'b0;
        endcase
    endfunction

    // stops after abort_after data bits when abort_after >= 0
    task automatic send_frame(input logic [7:0] d, input logic len8, input logic [1:0] m,
                              input logic flip, input logic stopv, input int abort_after);
        int nb;
        nb = len8 ? 8 : 7;
        @(negedge clk); rxd = 1'b0;
        wait_ticks(16);
        for (int b = 0; b < nb; b++) begin
            if (abort_after == b) begin
                rx_en = 1'b0;
                rxd   = 1'b1;
                wait_ticks(16 * (nb - b + 2));
                return;
            end
            rxd = d[b];
            wait_ticks(16);
        end
        if (m != 2'd0) begin
            rxd = par_of(d, len8, m) ^ flip;
            wait_ticks(16);
        end
        rxd = stopv;
        wait_ticks(16);
        rxd = 1'b1;
        wait_ticks(2);
    endtask

    task automatic do_read();
        @(negedge clk); rd_strobe = 1'b1;
        @(negedge clk); rd_strobe = 1'b0;
        @(negedge clk);
    endtask

    // {data, len8, par, route, flip, stop, exp_perr, exp_ferr}
    localparam logic [15:0] VEC [10] = '{
        {8'hA5, 1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        {8'h3C, 1'b1, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        {8'h3D, 1'b1, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
        {8'h7F, 1'b0, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        {8'hC1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        {8'h55, 1'b1, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        {8'h96, 1'b1, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
        {8'h96, 1'b1, 2'd2, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
        {8'h0F, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
        {8'h0F, 1'b0, 2'd3, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0}
    };

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int d0, e0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check({buf_full, err_parity, err_frame, err_overrun, irq_done, irq_err} == 6'b0,
              "R1 flags", {buf_full, err_parity, err_frame, err_overrun, irq_done, irq_err}, 0);
        check(rx_data == 8'h00, "R1 data", rx_data, 0);

        // R2 disabled receiver ignores the line
        d0 = n_done; e0 = n_err;
        send_frame(8'h5A, 1'b1, 2'd0, 1'b0, 1'b1, -1);
        check(!buf_full && rx_data == 8'h00, "R2 ignored", {buf_full, rx_data}, 0);
        check(n_done == d0 && n_err == e0, "R2 no pulse", n_done - d0 + n_err - e0, 0);

        rx_en = 1'b1;
        wait_ticks(4);

        // table walk: R4 R5 R6 R7 R8 R11
        foreach (VEC[i]) begin
            logic [7:0] vd, xd;
            logic vl, vr, vf, vs, xp, xf, xe;
            logic [1:0] vm;
            {vd, vl, vm, vr, vf, vs, xp, xf} = VEC[i];
            xd = vl ? vd : {1'b0, vd[6:0]};
            xe = xp | xf;
            char_len8 = vl; par_sel = vm; err_route = vr;
            d0 = n_done; e0 = n_err;
            send_frame(vd, vl, vm, vf, vs, -1);
            check(rx_data == xd, "R4 data", rx_data, xd);
            check(buf_full, "R7 full", buf_full, 1);
            check(err_parity == xp, "R5 parity", err_parity, xp);
            check(err_frame == xf, "R6 framing", err_frame, xf);
            check(n_err - e0 == int'(xe), "R8 err pulse", n_err - e0, xe);
            check(n_done - d0 == int'(!(xe && vr)), "R8 done pulse", n_done - d0, !(xe && vr));
            do_read();
            check(!buf_full && !err_parity && !err_frame && !err_overrun, "R11 read clears",
                  {buf_full, err_parity, err_frame, err_overrun}, 0);
        end

        // R3 short glitch then a clean frame
        char_len8 = 1'b1; par_sel = 2'd0; err_route = 1'b0;
        d0 = n_done; e0 = n_err;
        @(negedge clk); rxd = 1'b0;
        wait_ticks(3);
        rxd = 1'b1;
        wait_ticks(24);
        check(!buf_full && n_done == d0 && n_err == e0, "R3 glitch dropped",
              {buf_full, 8'(n_done - d0)}, 0);
        send_frame(8'hC3, 1'b1, 2'd0, 1'b0, 1'b1, -1);
        check(rx_data == 8'hC3 && n_done - d0 == 1, "R3 realign", rx_data, 8'hC3);
        do_read();

        // R10 overrun and stickiness
        send_frame(8'h11, 1'b1, 2'd0, 1'b0, 1'b1, -1);
        d0 = n_done; e0 = n_err;
        send_frame(8'h22, 1'b1, 2'd0, 1'b0, 1'b1, -1);
        check(err_overrun && rx_data == 8'h22, "R10 overrun", {err_overrun, rx_data}, 9'h122);
        check(n_err - e0 == 1, "R10 err pulse", n_err - e0, 1);
        wait_ticks(40);
        check(err_overrun && buf_full, "R10 sticky", {err_overrun, buf_full}, 3);
        do_read();
        check(!err_overrun && !buf_full, "R11 clear overrun", {err_overrun, buf_full}, 0);

        // R9 abort mid-frame keeps everything
        send_frame(8'h77, 1'b1, 2'd0, 1'b0, 1'b1, -1);
        do_read();
        d0 = n_done; e0 = n_err;
        send_frame(8'h88, 1'b1, 2'd0, 1'b0, 1'b1, 3);
        check(rx_data == 8'h77 && !buf_full, "R9 buffer kept", {buf_full, rx_data}, 8'h77);
        check(!err_parity && !err_frame && !err_overrun, "R9 flags kept",
              {err_parity, err_frame, err_overrun}, 0);
        check(n_done == d0 && n_err == e0, "R9 no pulse", n_done - d0 + n_err - e0, 0);
        rx_en = 1'b1;
        wait_ticks(4);
        send_frame(8'h3E, 1'b1, 2'd0, 1'b0, 1'b1, -1);
        check(rx_data == 8'h3E && buf_full, "R9 resumes", rx_data, 8'h3E);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule